// File: doc/BRIEF.md
# Shift, Rotate and Bit-Permute Unit

A purely combinational execution unit for a 32-bit integer pipeline that covers every shift-class operation. It handles logical and arithmetic right shifts, logical left shifts, shifts that fill with ones, rotates in both directions, full bit reversal, a byte-order swap and a per-byte OR-reduce that widens each byte into all-ones or all-zeros. The unit takes an operand, a 5-bit amount and an operation code, and returns a result in the same cycle.

There is only one barrel shifter, and it shifts right. Left-direction work mirrors the operand, shifts it right and mirrors the result back. The shifter runs on a 64-bit window. Its upper half holds the fill pattern: zeros, ones, copies of the sign bit, or a second copy of the operand for rotates. Bit reversal and byte swap are taken from the same mirror network. Instruction decode and register-file access belong to the surrounding pipeline.

Top module: `shift_rotate_permute`

## Requirements
- R1: Code 0 (shift left logical) returns the operand shifted left by `amount` with zeros in the vacated low bits. Code 1 (shift right logical) shifts right with zeros in the vacated high bits.
- R2: Code 2 (shift right arithmetic) shifts right and fills the vacated high bits with copies of operand bit 31.
- R3: Code 3 (shift left ones) and code 4 (shift right ones) behave like the logical shifts of R1, except that the vacated positions are filled with ones.
- R4: Code 5 (rotate left) and code 6 (rotate right) move the bits that leave one end of the operand into the vacated positions at the other end.
- R5: For codes 0 to 6, an `amount` of 0 returns the operand unchanged.
- R6: Code 7 (bit reverse) returns the operand with bit i moved to bit 31-i.
- R7: Code 8 (byte swap) returns the four bytes in reverse order: result byte k equals operand byte 3-k, where byte 0 is bits 7:0.
- R8: Code 9 (byte OR-combine) sets each result byte to 0xFF when any bit of the matching operand byte is 1, and to 0x00 otherwise.
- R9: For codes 7, 8 and 9, the value of `amount` has no effect on the result.
- R10: Codes 10 to 15 are unused and produce a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Data word to shift or permute |
| amount | input | 5 | Shift or rotate distance |
| op | input | 4 | Operation code, see R1 to R10 |
| result | output | 32 | Combinational result |

## Verification
The assertions are immediate checks on combinational values. They assume that `operand`, `amount` and `op` stay stable while a result is evaluated, and that every input bit is a known 0 or 1. The bench changes its inputs only on the falling clock edge and reads `result` one time step after the rising edge. Every value it drives is fully defined, which includes the unused operation codes. This means each check sees a settled, fully known combinational path.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [3:0] {
    OP_SLL  = 4'd0,
    OP_SRL  = 4'd1,
    OP_SRA  = 4'd2,
    OP_SLO  = 4'd3,
    OP_SRO  = 4'd4,
    OP_ROL  = 4'd5,
    OP_ROR  = 4'd6,
    OP_REV  = 4'd7,
    OP_BSWP = 4'd8,
    OP_ORCB = 4'd9
  } srp_op_e;

  // Source for the upper half of the 64-bit shift window
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONES = 2'd1,
    FILL_SIGN = 2'd2,
    FILL_COPY = 2'd3
  } srp_fill_e;

  // One-hot output select: bit 0 shifter, bit 1 byte swap, bit 2 OR-combine
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned SEL_SHIFT = 0;
  localparam int unsigned SEL_BSWP  = 1;
  localparam int unsigned SEL_ORCB  = 2;

  typedef struct packed {
    logic              mirrorIn;
    logic              mirrorOut;
    logic              killAmount;
    srp_fill_e         fill;
    logic [SEL_W-1:0]  outSel;
  } srp_strobe_t;

endpackage

// File: rtl/srp_mirror.sv
module srp_mirror #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign dOut[i] = dIn[WIDTH-1-i];
  end

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic [3:0]  opCode,
  output srp_strobe_t strb
);

  srp_op_e opDec;
  assign opDec = srp_op_e'(opCode);

  always_comb begin
    strb            = '0;
    strb.fill       = FILL_ZERO;
    case (opDec)
      OP_SLL: begin
        strb.mirrorIn  = 1'b1;
        strb.mirrorOut = 1'b1;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_SRL: strb.outSel[SEL_SHIFT] = 1'b1;
      OP_SRA: begin
        strb.fill = FILL_SIGN;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_SLO: begin
        strb.mirrorIn  = 1'b1;
        strb.mirrorOut = 1'b1;
        strb.fill      = FILL_ONES;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_SRO: begin
        strb.fill = FILL_ONES;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_ROL: begin
        strb.mirrorIn  = 1'b1;
        strb.mirrorOut = 1'b1;
        strb.fill      = FILL_COPY;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_ROR: begin
        strb.fill = FILL_COPY;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_REV: begin
        strb.mirrorIn   = 1'b1;
        strb.killAmount = 1'b1;
        strb.outSel[SEL_SHIFT] = 1'b1;
      end
      OP_BSWP: begin
        strb.killAmount = 1'b1;
        strb.outSel[SEL_BSWP] = 1'b1;
      end
      OP_ORCB: begin
        strb.killAmount = 1'b1;
        strb.outSel[SEL_ORCB] = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  always_comb begin
    p_sel_onehot_r10: assert ($onehot0(strb.outSel))
      else $error("output select not one-hot");
    p_unused_zero_r10: assert (!(opCode > 4'd9) || (strb.outSel == '0))
      else $error("unused code selects an output");
  end

endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  srp_strobe_t      strb,
  output logic [WIDTH-1:0] result
);

  localparam int unsigned WIN_W   = 2 * WIDTH;
  localparam int unsigned BYTES   = WIDTH / 8;

  logic [WIDTH-1:0] mirrored;
  logic [WIDTH-1:0] coreIn;
  logic [WIDTH-1:0] upperHalf;
  logic [WIN_W-1:0] window;
  logic [WIN_W-1:0] shiftedWin;
  logic [AMT_W-1:0] amtEff;
  logic [WIDTH-1:0] coreOut;
  logic [WIDTH-1:0] coreOutMirror;
  logic [WIDTH-1:0] shiftRes;
  logic [WIDTH-1:0] bswapRes;
  logic [WIDTH-1:0] orcbRes;

  // Input mirror, shared by left-direction ops, bit reverse and byte swap
  srp_mirror #(.WIDTH(WIDTH)) u_mirrorIn (
    .dIn  (operand),
    .dOut (mirrored)
  );

  assign coreIn = strb.mirrorIn ? mirrored : operand;
  assign amtEff = strb.killAmount ? '0 : amount;

  always_comb begin
    case (strb.fill)
      FILL_ONES: upperHalf = '1;
      FILL_SIGN: upperHalf = {WIDTH{operand[WIDTH-1]}};
      FILL_COPY: upperHalf = coreIn;
      default:   upperHalf = '0;
    endcase
  end

  assign window     = {upperHalf, coreIn};
  assign shiftedWin = window >> amtEff;
  assign coreOut    = shiftedWin[WIDTH-1:0];

  srp_mirror #(.WIDTH(WIDTH)) u_mirrorOut (
    .dIn  (coreOut),
    .dOut (coreOutMirror)
  );

  assign shiftRes = strb.mirrorOut ? coreOutMirror : coreOut;

  // Byte swap: the mirrored word holds bytes in swapped order but with bits
  // flipped inside each byte; undo the in-byte flip by wiring.
  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign bswapRes[8*b+k] = mirrored[8*b+7-k];
    end
    assign orcbRes[8*b +: 8] = {8{|operand[8*b +: 8]}};
  end

  always_comb begin
    unique case (1'b1)
      strb.outSel[SEL_SHIFT]: result = shiftRes;
      strb.outSel[SEL_BSWP]:  result = bswapRes;
      strb.outSel[SEL_ORCB]:  result = orcbRes;
      default:                result = '0;
    endcase
  end

  always_comb begin
    p_zero_amt_r5: assert (!(strb.outSel[SEL_SHIFT] && !strb.killAmount &&
                             amount == '0) || (result == operand))
      else $error("zero amount changed the operand");
    p_sra_msb_r2: assert (!(strb.outSel[SEL_SHIFT] && strb.fill == FILL_SIGN)
                          || (result[WIDTH-1] == operand[WIDTH-1]))
      else $error("arithmetic shift lost the sign");
    p_rev_ends_r6: assert (!(strb.outSel[SEL_SHIFT] && strb.killAmount) ||
                           (result[0] == operand[WIDTH-1] &&
                            result[WIDTH-1] == operand[0]))
      else $error("bit reverse end bits wrong");
    p_bswap_low_r7: assert (!strb.outSel[SEL_BSWP] ||
                            (result[7:0] == operand[WIDTH-1 -: 8]))
      else $error("byte swap low byte wrong");
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_orcb_chk
    always_comb begin
      p_orcb_byte_r8: assert (!strb.outSel[SEL_ORCB] ||
                              ($countones(result[8*b +: 8]) ==
                               ((operand[8*b +: 8] != 8'h00) ? 8 : 0)))
        else $error("OR-combine byte %0d wrong", b);
    end
  end

endmodule

// File: rtl/shift_rotate_permute.sv
module shift_rotate_permute
  import srp_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] result
);

  srp_strobe_t strb;

  srp_ctrl u_ctrl (
    .opCode (op),
    .strb   (strb)
  );

  srp_datapath #(
    .WIDTH (WIDTH),
    .AMT_W (AMT_W)
  ) u_datapath (
    .operand (operand),
    .amount  (amount),
    .strb    (strb),
    .result  (result)
  );

endmodule

// File: tb/shift_rotate_permute_bench.sv
module shift_rotate_permute_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] operand = '0;
  logic [4:0]  amount  = '0;
  logic [3:0]  op      = '0;
  logic [31:0] result;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_permute u_shift_rotate_permute (
    .operand (operand),
    .amount  (amount),
    .op      (op),
    .result  (result)
  );

  function automatic logic [31:0] bitrev(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = x[31-i];
    return r;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x,
                                        input logic [4:0] a,
                                        input logic [3:0] c);
    logic [31:0] r;
    r = '0;
    case (c)
      4'd0: r = x << a;
      4'd1: r = x >> a;
      4'd2: r = 32'($signed(x) >>> a);
      4'd3: r = ~((~x) << a);
      4'd4: r = ~((~x) >> a);
      4'd5: r = (a == 0) ? x : ((x << a) | (x >> (6'd32 - {1'b0, a})));
      4'd6: r = (a == 0) ? x : ((x >> a) | (x << (6'd32 - {1'b0, a})));
      4'd7: r = bitrev(x);
      4'd8: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
      4'd9: for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{|x[8*b +: 8]}};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string reqOf(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: return "R1";
      4'd2:       return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6: return "R4";
      4'd7:       return "R6";
      4'd8:       return "R7";
      4'd9:       return "R8";
      default:    return "R10";
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [4:0] a,
                       input logic [3:0] c, input string req);
    logic [31:0] exp;
    @(negedge clk);
    operand = x; amount = a; op = c;
    @(posedge clk);
    #1;
    exp = model(x, a, c);
    testsRun++;
    if (result !== exp) begin
      testsFailed++;
      $display("FAIL %s op=%0d amt=%0d opnd=%h got=%h exp=%h",
               req, c, a, x, result, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: all-zero inputs give zero (R1)
    #1;
    testsRun++;
    if (result !== 32'h0) begin
      testsFailed++;
      $display("FAIL R1 idle got=%h exp=%h", result, 32'h0);
    end

    // Directed corners
    apply(32'h8000_0001, 5'd1,  4'd0, "R1");
    apply(32'h8000_0001, 5'd31, 4'd1, "R1");
    apply(32'h8000_0000, 5'd31, 4'd2, "R2");
    apply(32'h7FFF_FFFF, 5'd4,  4'd2, "R2");
    apply(32'h0000_0000, 5'd31, 4'd3, "R3");
    apply(32'h0000_0000, 5'd7,  4'd4, "R3");
    apply(32'h8000_0001, 5'd1,  4'd5, "R4");
    apply(32'h8000_0001, 5'd1,  4'd6, "R4");
    apply(32'h1234_5678, 5'd31, 4'd5, "R4");
    for (int c = 0; c < 7; c++) apply(32'hDEAD_BEEF, 5'd0, 4'(c), "R5");
    apply(32'h0000_0001, 5'd0,  4'd7, "R6");
    apply(32'h1234_5678, 5'd0,  4'd8, "R7");
    apply(32'h0010_8000, 5'd0,  4'd9, "R8");
    apply(32'h0000_0000, 5'd0,  4'd9, "R8");
    apply(32'h1234_5678, 5'd19, 4'd7, "R9");
    apply(32'h1234_5678, 5'd31, 4'd8, "R9");
    apply(32'h0100_0080, 5'd5,  4'd9, "R9");
    for (int c = 10; c < 16; c++) apply(32'hFFFF_FFFF, 5'd3, 4'(c), "R10");

    // Random operands across every code and every amount
    void'($urandom(32'd2024));
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 32; a++) begin
        for (int n = 0; n < 8; n++) begin
          logic [31:0] x;
          x = $urandom();
          if (n == 1) x = x & 32'hFF00_00FF;
          if (n == 2) x = 32'h8000_0000 | x;
          apply(x, 5'(a), 4'(c), (a == 0 && c < 7) ? "R5" : reqOf(4'(c)));
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule